// File: doc/BRIEF.md
# Packet Radio Transmit Framing Sequencer

This block drives the byte stream of a half-duplex packet radio modem. An outside arbiter raises a start pulse. The block then keys the transmitter through a push-to-talk output and counts out a preamble. It takes one frame from a host-side byte FIFO, emits the frame's payload, and appends a two-byte frame check sequence. After the check sequence it either chains straight into the next queued frame or counts out a tail before releasing the key.

The block advances one step for each "modem ready for byte" strobe. Bit-level flag insertion and bit stuffing happen downstream. The preamble and tail lengths are computed from the configured bit rate and millisecond settings. In one duplex mode the tail is extended by a hold delay given in seconds.

The FIFO presents the head frame's length tag and current byte. The block consumes one byte with a pop strobe, or discards the whole head frame with a skip strobe.

Top module: `prtx_seq`

## Requirements
- R1: After reset `ptt_o`, `busy_o` and `byte_vld_o` are low, and `frames_o` is zero.
- R2: A start pulse while idle raises `ptt_o` and `busy_o` one cycle later. The preamble then lasts max(1, rate×txdelay_ms/8000) strobes, or exactly 1 strobe when txdelay_ms is 0, and emits no bytes. Its last strobe takes the head frame's command byte.
- R3: If no frame is queued when the preamble count expires, `ptt_o` and `busy_o` fall one cycle after that strobe.
- R4: A head frame is accepted only when its first byte is 0x00 and its payload length (`q_len_i` − 1) is between 2 and 1023. Any other frame is dropped with `q_skip_o` and emits no byte. The next frame is examined on the following strobe.
- R5: Each payload byte appears on `byte_o` with a one-cycle `byte_vld_o` pulse, one cycle after the strobe that sends it, in FIFO order and one byte per strobe.
- R6: The check sequence is a reflected CRC-16 (polynomial 0x8408, preset 0xFFFF) over the payload bytes only, complemented. Its low byte goes out on the strobe after the last payload byte and its high byte on the strobe after that. The payload "123456789" yields 0x6E then 0x90.
- R7: If a frame is queued when the high check byte is sent, the next strobe takes that frame's command byte without any byte output, and `ptt_o` stays high.
- R8: If no frame is queued after the high check byte, the tail lasts max(1, T) strobes with no byte output, and `ptt_o` falls one cycle after the last tail strobe.
- R9: In duplex mode 2, T is rate×txtail_ms/8000 + rate×hold_s/8. In any other mode T is rate×txtail_ms/8000.
- R10: A start pulse during the tail restarts transmission with a one-strobe preamble. A start pulse during the preamble, the data or the check bytes has no effect.
- R11: `frames_o` increments by one for each high check byte sent. `busy_o` is high whenever the block is not idle.
- R12: A ready strobe while idle emits nothing and leaves `ptt_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Transmit request pulse from the arbiter |
| byte_rdy_i | input | 1 | Modem ready for next byte strobe |
| rate_i | input | RATE_W | Bit rate in bit/s |
| txdelay_ms_i | input | MS_W | Preamble time in ms |
| txtail_ms_i | input | MS_W | Tail time in ms |
| hold_s_i | input | HOLD_W | Hold delay in s (duplex mode 2 only) |
| duplex_mode_i | input | 2 | Duplex mode select |
| q_valid_i | input | 1 | FIFO holds at least one frame |
| q_len_i | input | LEN_W | Head frame length including command byte |
| q_data_i | input | 8 | Current FIFO byte |
| q_pop_o | output | 1 | Consume current FIFO byte |
| q_skip_o | output | 1 | Discard whole head frame |
| byte_o | output | 8 | Byte to modem |
| byte_vld_o | output | 1 | `byte_o` valid pulse |
| ptt_o | output | 1 | Transmitter key |
| busy_o | output | 1 | Sequencer not idle |
| frames_o | output | FRM_W | Frames sent |

## Verification
The FIFO controls `q_pop_o` and `q_skip_o` act combinationally in the cycle of the strobe. `byte_o`, `byte_vld_o`, `ptt_o`, `busy_o` and `frames_o` change one cycle after the strobe or start edge that causes them. The bench raises each strobe or start for exactly one cycle, driving on the falling edge. It checks on the next falling edge, where the registered results of that single edge are visible and the `byte_vld_o` pulse has not yet ended. Preamble and tail lengths are checked by counting strobes: on the last strobe the key must drop, and on the one before it the key must still be held.

// File: rtl/prtx_pkg.sv
`timescale 1ns/1ps
package prtx_pkg;

  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_HEAD   = 3'd1,
    ST_DATA   = 3'd2,
    ST_FCS_LO = 3'd3,
    ST_FCS_HI = 3'd4,
    ST_TAIL   = 3'd5
  } tx_state_e;

  localparam logic [15:0] FCS_POLY = 16'h8408;
  localparam logic [15:0] FCS_INIT = 16'hFFFF;

  // one byte through the reflected CRC-16, LSB first
  function automatic logic [15:0] fcs_step(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c;
    c = crc ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ FCS_POLY) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/prtx_timing.sv
`timescale 1ns/1ps
module prtx_timing #(
  parameter int RATE_W    = 17,
  parameter int MS_W      = 10,
  parameter int HOLD_W    = 8,
  parameter int CNT_W     = 27,
  parameter int HOLD_MODE = 2
) (
  input  logic [RATE_W-1:0] rate_i,
  input  logic [MS_W-1:0]   txdelay_ms_i,
  input  logic [MS_W-1:0]   txtail_ms_i,
  input  logic [HOLD_W-1:0] hold_s_i,
  input  logic [1:0]        duplex_mode_i,
  output logic [CNT_W-1:0]  head_cnt_o,
  output logic [CNT_W-1:0]  tail_cnt_o
);
  localparam int PW = RATE_W + MS_W;
  localparam int HW = RATE_W + HOLD_W;
  // bytes per ms at 1 bit/s is 1/8000
  localparam logic [PW-1:0] MS_PER_BYTE = PW'(8000);

  logic [PW-1:0]    pre_prod, pre_q, tail_prod, tail_q;
  logic [HW-1:0]    hold_prod, hold_q;
  logic [CNT_W-1:0] tail_sum;
  logic             hold_on;

  assign pre_prod  = {{MS_W{1'b0}}, rate_i} * {{RATE_W{1'b0}}, txdelay_ms_i};
  assign tail_prod = {{MS_W{1'b0}}, rate_i} * {{RATE_W{1'b0}}, txtail_ms_i};
  assign hold_prod = {{HOLD_W{1'b0}}, rate_i} * {{RATE_W{1'b0}}, hold_s_i};

  assign pre_q  = pre_prod / MS_PER_BYTE;
  assign tail_q = tail_prod / MS_PER_BYTE;
  assign hold_q = hold_prod >> 3;

  assign hold_on  = (duplex_mode_i == 2'(HOLD_MODE));
  assign tail_sum = CNT_W'(tail_q) + (hold_on ? CNT_W'(hold_q) : '0);

  always_comb begin
    if (txdelay_ms_i == '0 || pre_q == '0) head_cnt_o = CNT_W'(1);
    else                                   head_cnt_o = CNT_W'(pre_q);
  end

  assign tail_cnt_o = (tail_sum == '0) ? CNT_W'(1) : tail_sum;

endmodule

// File: rtl/prtx_fcs.sv
`timescale 1ns/1ps
module prtx_fcs
  import prtx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] fcs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fcs_o <= FCS_INIT;
    else if (init_i) fcs_o <= FCS_INIT;
    else if (en_i)   fcs_o <= fcs_step(fcs_o, byte_i);
  end
endmodule

// File: rtl/prtx_ctrl.sv
`timescale 1ns/1ps
module prtx_ctrl
  import prtx_pkg::*;
#(
  parameter int CNT_W   = 27,
  parameter int LEN_W   = 11,
  parameter int MIN_PAY = 2,
  parameter int MAX_PAY = 1023
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             byte_rdy_i,
  input  logic             q_valid_i,
  input  logic [LEN_W-1:0] q_len_i,
  input  logic [7:0]       q_cmd_i,
  input  logic [CNT_W-1:0] head_cnt_i,
  input  logic [CNT_W-1:0] tail_cnt_i,
  output tx_state_e        state_o,
  output logic             q_pop_o,
  output logic             q_skip_o,
  output logic             fcs_init_o,
  output logic             send_data_o,
  output logic             send_lo_o,
  output logic             send_hi_o,
  output logic             ptt_o
);
  localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_PAY + 1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_PAY + 1);

  tx_state_e        st;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] left;
  logic             cnt_last, hdr_ok, head_take, restart;

  assign cnt_last  = (cnt <= CNT_W'(1));
  assign hdr_ok    = (q_cmd_i == 8'h00) && (q_len_i >= LEN_MIN) && (q_len_i <= LEN_MAX);
  assign head_take = byte_rdy_i && (st == ST_HEAD) && cnt_last && q_valid_i;
  assign restart   = start_i && ((st == ST_OFF) || (st == ST_TAIL));

  assign send_data_o = byte_rdy_i && (st == ST_DATA);
  assign send_lo_o   = byte_rdy_i && (st == ST_FCS_LO);
  assign send_hi_o   = byte_rdy_i && (st == ST_FCS_HI);
  assign fcs_init_o  = head_take && hdr_ok;
  assign q_pop_o     = (head_take && hdr_ok) || send_data_o;
  assign q_skip_o    = head_take && !hdr_ok;
  assign state_o     = st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st    <= ST_OFF;
      cnt   <= '0;
      left  <= '0;
      ptt_o <= 1'b0;
    end else if (restart) begin
      st    <= ST_HEAD;
      cnt   <= (st == ST_TAIL) ? CNT_W'(1) : head_cnt_i;
      ptt_o <= 1'b1;
    end else if (byte_rdy_i) begin
      unique case (st)
        ST_HEAD: begin
          if (!cnt_last) begin
            cnt <= cnt - CNT_W'(1);
          end else if (!q_valid_i) begin
            st    <= ST_OFF;
            ptt_o <= 1'b0;
          end else if (hdr_ok) begin
            st   <= ST_DATA;
            left <= q_len_i - LEN_W'(1);
          end
          // rejected frame: stay in HEAD with count 1
        end
        ST_DATA: begin
          left <= left - LEN_W'(1);
          if (left == LEN_W'(1)) st <= ST_FCS_LO;
        end
        ST_FCS_LO: st <= ST_FCS_HI;
        ST_FCS_HI: begin
          if (q_valid_i) begin
            st  <= ST_HEAD;
            cnt <= CNT_W'(1);
          end else begin
            st  <= ST_TAIL;
            cnt <= tail_cnt_i;
          end
        end
        ST_TAIL: begin
          if (cnt_last) begin
            st    <= ST_OFF;
            ptt_o <= 1'b0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  // R8
  cnt_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_HEAD || st == ST_TAIL) |-> (cnt != '0));

  // R4
  pop_skip_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(q_pop_o && q_skip_o));

  // R5
  data_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_DATA) |-> (left != '0));

endmodule

// File: rtl/prtx_seq.sv
`timescale 1ns/1ps
module prtx_seq
  import prtx_pkg::*;
#(
  parameter int RATE_W    = 17,
  parameter int MS_W      = 10,
  parameter int HOLD_W    = 8,
  parameter int LEN_W     = 11,
  parameter int FRM_W     = 16,
  parameter int MIN_PAY   = 2,
  parameter int MAX_PAY   = 1023,
  parameter int HOLD_MODE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              byte_rdy_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [MS_W-1:0]   txdelay_ms_i,
  input  logic [MS_W-1:0]   txtail_ms_i,
  input  logic [HOLD_W-1:0] hold_s_i,
  input  logic [1:0]        duplex_mode_i,
  input  logic              q_valid_i,
  input  logic [LEN_W-1:0]  q_len_i,
  input  logic [7:0]        q_data_i,
  output logic              q_pop_o,
  output logic              q_skip_o,
  output logic [7:0]        byte_o,
  output logic              byte_vld_o,
  output logic              ptt_o,
  output logic              busy_o,
  output logic [FRM_W-1:0]  frames_o
);
  localparam int CNT_W = RATE_W + ((MS_W > HOLD_W) ? MS_W : HOLD_W);

  logic [CNT_W-1:0] head_cnt, tail_cnt;
  logic [15:0]      fcs;
  logic             fcs_init, send_data, send_lo, send_hi;
  tx_state_e        state;

  prtx_timing #(
    .RATE_W(RATE_W), .MS_W(MS_W), .HOLD_W(HOLD_W), .CNT_W(CNT_W), .HOLD_MODE(HOLD_MODE)
  ) timing_i (
    .rate_i(rate_i), .txdelay_ms_i(txdelay_ms_i), .txtail_ms_i(txtail_ms_i),
    .hold_s_i(hold_s_i), .duplex_mode_i(duplex_mode_i),
    .head_cnt_o(head_cnt), .tail_cnt_o(tail_cnt)
  );

  prtx_ctrl #(
    .CNT_W(CNT_W), .LEN_W(LEN_W), .MIN_PAY(MIN_PAY), .MAX_PAY(MAX_PAY)
  ) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .byte_rdy_i(byte_rdy_i),
    .q_valid_i(q_valid_i), .q_len_i(q_len_i), .q_cmd_i(q_data_i),
    .head_cnt_i(head_cnt), .tail_cnt_i(tail_cnt),
    .state_o(state), .q_pop_o(q_pop_o), .q_skip_o(q_skip_o), .fcs_init_o(fcs_init),
    .send_data_o(send_data), .send_lo_o(send_lo), .send_hi_o(send_hi), .ptt_o(ptt_o)
  );

  prtx_fcs fcs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .init_i(fcs_init), .en_i(send_data),
    .byte_i(q_data_i), .fcs_o(fcs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o     <= 8'h00;
      byte_vld_o <= 1'b0;
      frames_o   <= '0;
    end else begin
      byte_vld_o <= send_data | send_lo | send_hi;
      if (send_data)    byte_o <= q_data_i;
      else if (send_lo) byte_o <= ~fcs[7:0];
      else if (send_hi) byte_o <= ~fcs[15:8];
      if (send_hi) frames_o <= frames_o + FRM_W'(1);
    end
  end

  assign busy_o = (state != ST_OFF);

  // R5
  vld_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(byte_rdy_i));

  // R2
  ptt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ptt_o) |-> $past(start_i));

  // R11
  busy_ptt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == ptt_o);

  // R11
  frame_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frames_o != $past(frames_o)) |-> (frames_o == $past(frames_o) + FRM_W'(1)));

endmodule

// File: tb/prtx_seq_tb_top.sv
`timescale 1ns/1ps
module prtx_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, rdy = 1'b0;
  logic [16:0] rate = 17'd1200;
  logic [9:0]  txd = 10'd20, ttl = 10'd20;
  logic [7:0]  hold = 8'd0;
  logic [1:0]  mode = 2'd0;
  logic        q_valid, q_pop, q_skip, vld, ptt, busy;
  logic [10:0] q_len;
  logic [7:0]  q_data, byte_out;
  logic [15:0] frames;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] last_lo, last_hi;

  always #2.5 clk = ~clk;

  // frame FIFO model
  logic [7:0] fbuf [0:2047];
  int flen [0:31];
  int fbase[0:31];
  int fh = 0, ft = 0, off = 0, wp = 0;

  assign q_valid = (fh != ft);
  assign q_len   = q_valid ? 11'(flen[fh]) : 11'd0;
  assign q_data  = q_valid ? fbuf[fbase[fh] + off] : 8'h00;

  always @(posedge clk) begin
    if (q_pop) begin
      if (off + 1 == flen[fh]) begin fh <= fh + 1; off <= 0; end
      else off <= off + 1;
    end else if (q_skip) begin
      fh <= fh + 1; off <= 0;
    end
  end

  prtx_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_rdy_i(rdy),
    .rate_i(rate), .txdelay_ms_i(txd), .txtail_ms_i(ttl), .hold_s_i(hold),
    .duplex_mode_i(mode), .q_valid_i(q_valid), .q_len_i(q_len), .q_data_i(q_data),
    .q_pop_o(q_pop), .q_skip_o(q_skip), .byte_o(byte_out), .byte_vld_o(vld),
    .ptt_o(ptt), .busy_o(busy), .frames_o(frames)
  );

  function automatic logic [7:0] pbyte(input int kind, input int i);
    if (kind == 0) return 8'(8'h31 + i);
    return 8'((i * 37 + kind * 11) & 255);
  endfunction

  function automatic logic [15:0] crc_add(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int k = 0; k < 8; k++) begin
      fb = r[0] ^ b[k];
      r = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic add_frame(input logic [7:0] cmd, input int n, input int kind);
    fbase[ft] = wp;
    flen[ft]  = n + 1;
    fbuf[wp]  = cmd;
    for (int i = 0; i < n; i++) fbuf[wp + 1 + i] = pbyte(kind, i);
    wp = wp + n + 1;
    ft = ft + 1;
  endtask

  task automatic strobe();
    @(negedge clk) rdy = 1'b1;
    @(negedge clk) rdy = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic quiet_strobes(input int k, input string req);
    for (int i = 0; i < k; i++) begin
      strobe();
      chk(req, int'({vld, ptt}), int'(2'b01));
    end
  endtask

  task automatic expect_frame(input int kind, input int n);
    logic [15:0] c;
    logic [7:0] b;
    c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      b = pbyte(kind, i);
      c = crc_add(c, b);
      strobe();
      chk("R5 payload byte", int'({vld, byte_out}), int'({1'b1, b}));
    end
    c = ~c;
    strobe();
    last_lo = byte_out;
    chk("R6 fcs low", int'({vld, byte_out}), int'({1'b1, c[7:0]}));
    strobe();
    last_hi = byte_out;
    chk("R6 fcs high", int'({vld, byte_out}), int'({1'b1, c[15:8]}));
  endtask

  task automatic expect_tail(input int n, input string req);
    quiet_strobes(n - 1, req);
    strobe();
    chk(req, int'({vld, ptt, busy}), 0);
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", int'({busy, ptt, vld}), 0);
    chk("R1 frame count", int'(frames), 0);
    strobe();
    chk("R12 idle strobe", int'({busy, ptt, vld}), 0);
  endtask

  task automatic t_preamble_empty();
    rate = 17'd1200; txd = 10'd20;
    pulse_start();
    chk("R2 key on", int'({ptt, busy}), 3);
    quiet_strobes(2, "R2 preamble held");
    strobe();
    chk("R3 empty queue drop", int'({ptt, busy}), 0);
    txd = 10'd0;
    pulse_start();
    strobe();
    chk("R2 zero delay one strobe", int'({ptt, busy}), 0);
  endtask

  task automatic t_default_timing();
    rate = 17'd9600; txd = 10'd300;
    pulse_start();
    quiet_strobes(359, "R2 default preamble");
    strobe();
    chk("R2 default preamble end", int'(ptt), 0);
  endtask

  task automatic t_single();
    rate = 17'd1200; txd = 10'd20; ttl = 10'd20; mode = 2'd0;
    add_frame(8'h00, 9, 0);
    pulse_start();
    quiet_strobes(3, "R2 preamble before data");
    chk("R11 busy in frame", int'(busy), 1);
    expect_frame(0, 9);
    chk("R6 known vector", int'({last_hi, last_lo}), 16'h906E);
    chk("R11 frame count", int'(frames), 1);
    expect_tail(3, "R8 tail");
  endtask

  task automatic t_b2b();
    add_frame(8'h00, 5, 3);
    add_frame(8'h00, 2, 4);
    pulse_start();
    quiet_strobes(3, "R2 preamble");
    expect_frame(3, 5);
    quiet_strobes(1, "R7 chained head");
    expect_frame(4, 2);
    chk("R11 frame count b2b", int'(frames), 3);
    expect_tail(3, "R8 tail after chain");
  endtask

  task automatic t_bad();
    txd = 10'd0;
    add_frame(8'h7E, 4, 5);
    add_frame(8'h00, 1, 5);
    add_frame(8'h00, 1024, 5);
    add_frame(8'h00, 2, 6);
    pulse_start();
    quiet_strobes(3, "R4 rejected frames");
    quiet_strobes(1, "R4 accepted command");
    expect_frame(6, 2);
    chk("R4 queue drained", int'(q_valid), 0);
    chk("R4 only good frame counted", int'(frames), 4);
    expect_tail(3, "R8 tail");
  endtask

  task automatic t_duplex();
    rate = 17'd8; txd = 10'd0; ttl = 10'd0; hold = 8'd3; mode = 2'd2;
    add_frame(8'h00, 2, 7);
    pulse_start();
    quiet_strobes(1, "R2 preamble");
    expect_frame(7, 2);
    expect_tail(3, "R9 hold extension");
    mode = 2'd1;
    add_frame(8'h00, 2, 7);
    pulse_start();
    quiet_strobes(1, "R2 preamble");
    expect_frame(7, 2);
    expect_tail(1, "R9 no extension, R8 minimum");
  endtask

  task automatic t_restart();
    rate = 17'd1200; txd = 10'd20; ttl = 10'd34; mode = 2'd0;
    add_frame(8'h00, 3, 8);
    pulse_start();
    quiet_strobes(1, "R2 preamble");
    pulse_start();
    quiet_strobes(2, "R10 start ignored in head");
    expect_frame(8, 3);
    quiet_strobes(2, "R8 tail");
    add_frame(8'h00, 2, 9);
    pulse_start();
    chk("R10 restart busy", int'({ptt, busy}), 3);
    quiet_strobes(1, "R10 one strobe preamble");
    expect_frame(9, 2);
    expect_tail(5, "R8 tail 5");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_preamble_empty();
    t_default_timing();
    t_single();
    t_b2b();
    t_bad();
    t_duplex();
    t_restart();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule